// File: doc/BRIEF.md
# Bundle-Indexed Program Counter Sequencer

This block keeps the fetch address for a processor whose instructions sit in fixed-size bundles, each bundle holding a variable number of instructions. The program counter is one instruction wide in granularity. Its low bits give the slot of an instruction inside a bundle, and its high bits give the bundle number. The fetch stage reads a small field at the head of every bundle. That field holds the index of the bundle's final instruction, so a bundle of two instructions carries 1. The fetch stage supplies this field for the current bundle, and for the target bundle whenever a branch is requested.

On each advance strobe the sequencer moves to the next slot. After the final slot it steps to slot 0 of the following bundle. A taken branch loads a new PC, but only after its slot has been checked against the target bundle's last-index field. If the slot lies beyond that field, the branch is refused and an error flag is raised. A one-cycle bundle-change pulse tells the fetch unit that a new line must be requested.

Top module: `bundle_pc_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, the PC is 0 and both bundle_chg_o and pc_err_o are 0.
- R2: With advance high, no branch, and a current slot below cur_last_i, the next PC keeps its bundle number, its slot rises by one, and bundle_chg_o is 0.
- R3: With advance high, no branch, and a current slot equal to or above cur_last_i, the next PC is slot 0 of the next bundle, and bundle_chg_o is 1 for exactly that one cycle.
- R4: With neither advance nor branch, the PC holds and bundle_chg_o is 0.
- R5: A branch whose target slot is not above tgt_last_i loads the target PC on the next cycle and clears pc_err_o.
- R6: After an accepted branch, bundle_chg_o is 1 if the target bundle number differs from the current one and 0 if it is the same.
- R7: A branch whose target slot is above tgt_last_i sets pc_err_o, leaves the PC unchanged (any advance in the same cycle is dropped), and keeps bundle_chg_o at 0.
- R8: Once set, pc_err_o stays 1 through idle and advance cycles and through further refused branches, until an accepted branch or reset. Advances still move the PC while the flag is set.
- R9: A branch in the same cycle as an advance takes priority: the advance has no effect.
- R10: The slot occupies the low OFS_W bits of the PC: 3 bits for a 128-bit bundle (the default) and 4 bits for a 256-bit bundle. The bundle number fills the remaining bits of the 32-bit PC and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance to the next instruction |
| cur_last_i | input | OFS_W | Last-index field of the current bundle |
| br_valid_i | input | 1 | Taken-branch request |
| br_target_i | input | PC_W | Branch target PC |
| tgt_last_i | input | OFS_W | Last-index field of the target bundle |
| pc_o | output | PC_W | Current PC (bundle number high, slot low) |
| bundle_chg_o | output | 1 | One-cycle pulse when the bundle number changes |
| pc_err_o | output | 1 | Refused branch target, held until an accepted branch |

## Verification
All three outputs come from registers. Any stimulus presented before a rising edge therefore shows its result on pc_o, bundle_chg_o and pc_err_o right after that edge, a latency of exactly one cycle. The bench changes its inputs on the falling edge, lets one rising edge pass, and compares at the next falling edge. Every table row and directed step is checked in the cycle its result is due. The single-cycle width of the bundle-change pulse is confirmed by an idle step right after a wrap.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  // Slot field width for a given bundle size in bits
  function automatic int unsigned slot_width(input int unsigned bundle_bits);
    return (bundle_bits >= 256) ? 4 : 3;
  endfunction

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_JUMP   = 2'd2,
    ACT_REJECT = 2'd3
  } pc_act_e;

endpackage

// File: rtl/bpc_step_unit.sv
module bpc_step_unit #(
  parameter int unsigned OFS_W  = 3,
  parameter int unsigned BNUM_W = 29
) (
  input  logic [BNUM_W-1:0] bnum_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [OFS_W-1:0]  last_i,
  output logic [BNUM_W-1:0] nxt_bnum_o,
  output logic [OFS_W-1:0]  nxt_ofs_o,
  output logic              wrap_o
);
  // A slot at or past the bundle's last index moves on to the next bundle
  always_comb begin
    wrap_o = (ofs_i >= last_i);
    if (wrap_o) begin
      nxt_bnum_o = bnum_i + 1'b1;
      nxt_ofs_o  = '0;
    end else begin
      nxt_bnum_o = bnum_i;
      nxt_ofs_o  = ofs_i + 1'b1;
    end
  end
endmodule

// File: rtl/bpc_target_chk.sv
module bpc_target_chk #(
  parameter int unsigned OFS_W  = 3,
  parameter int unsigned BNUM_W = 29
) (
  input  logic [BNUM_W+OFS_W-1:0] tgt_i,
  input  logic [OFS_W-1:0]        tgt_last_i,
  input  logic [BNUM_W-1:0]       cur_bnum_i,
  output logic                    ok_o,
  output logic                    cross_o
);
  logic [OFS_W-1:0]  tgt_ofs;
  logic [BNUM_W-1:0] tgt_bnum;

  always_comb begin
    tgt_ofs  = tgt_i[OFS_W-1:0];
    tgt_bnum = tgt_i[BNUM_W+OFS_W-1:OFS_W];
    ok_o     = (tgt_ofs <= tgt_last_i);
    cross_o  = (tgt_bnum != cur_bnum_i);
  end
endmodule

// File: rtl/bpc_arbiter.sv
module bpc_arbiter
  import bpc_pkg::*;
(
  input  logic    br_valid_i,
  input  logic    adv_i,
  input  logic    tgt_ok_i,
  output pc_act_e act_o
);
  // A branch request always wins over a sequential advance
  always_comb begin
    if (br_valid_i)  act_o = tgt_ok_i ? ACT_JUMP : ACT_REJECT;
    else if (adv_i)  act_o = ACT_STEP;
    else             act_o = ACT_HOLD;
  end
endmodule

// File: rtl/bundle_pc_seq.sv
module bundle_pc_seq
  import bpc_pkg::*;
#(
  parameter int unsigned BUNDLE_BITS = 128,
  parameter int unsigned PC_W        = 32,
  localparam int unsigned OFS_W      = slot_width(BUNDLE_BITS),
  localparam int unsigned BNUM_W     = PC_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [OFS_W-1:0] cur_last_i,
  input  logic             br_valid_i,
  input  logic [PC_W-1:0]  br_target_i,
  input  logic [OFS_W-1:0] tgt_last_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             bundle_chg_o,
  output logic             pc_err_o
);

  logic [BNUM_W-1:0] bnum_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              chg_q;
  logic              err_q;

  logic [BNUM_W-1:0] step_bnum;
  logic [OFS_W-1:0]  step_ofs;
  logic              step_wrap;
  logic              tgt_ok;
  logic              tgt_cross;
  pc_act_e           act;

  bpc_step_unit #(.OFS_W(OFS_W), .BNUM_W(BNUM_W)) u_step (
    .bnum_i     (bnum_q),
    .ofs_i      (ofs_q),
    .last_i     (cur_last_i),
    .nxt_bnum_o (step_bnum),
    .nxt_ofs_o  (step_ofs),
    .wrap_o     (step_wrap)
  );

  bpc_target_chk #(.OFS_W(OFS_W), .BNUM_W(BNUM_W)) u_chk (
    .tgt_i      (br_target_i),
    .tgt_last_i (tgt_last_i),
    .cur_bnum_i (bnum_q),
    .ok_o       (tgt_ok),
    .cross_o    (tgt_cross)
  );

  bpc_arbiter u_arb (
    .br_valid_i (br_valid_i),
    .adv_i      (adv_i),
    .tgt_ok_i   (tgt_ok),
    .act_o      (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bnum_q <= '0;
      ofs_q  <= '0;
      chg_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      unique case (act)
        ACT_JUMP: begin
          bnum_q <= br_target_i[PC_W-1:OFS_W];
          ofs_q  <= br_target_i[OFS_W-1:0];
          chg_q  <= tgt_cross;
          err_q  <= 1'b0;
        end
        ACT_REJECT: begin
          err_q <= 1'b1;
        end
        ACT_STEP: begin
          bnum_q <= step_bnum;
          ofs_q  <= step_ofs;
          chg_q  <= step_wrap;
        end
        default: ;
      endcase
    end
  end

  assign pc_o         = {bnum_q, ofs_q};
  assign bundle_chg_o = chg_q;
  assign pc_err_o     = err_q;

  // R1: outputs cleared on the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !bundle_chg_o && !pc_err_o));

  // R2: in-bundle advance
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!br_valid_i && adv_i && pc_o[OFS_W-1:0] < cur_last_i) |=>
      (pc_o[OFS_W-1:0] == OFS_W'($past(pc_o[OFS_W-1:0]) + 1'b1)) &&
      (pc_o[PC_W-1:OFS_W] == $past(pc_o[PC_W-1:OFS_W])) && !bundle_chg_o);

  // R3: wrap to next bundle
  assert_bundle_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!br_valid_i && adv_i && pc_o[OFS_W-1:0] >= cur_last_i) |=>
      (pc_o[OFS_W-1:0] == '0) && bundle_chg_o &&
      (pc_o[PC_W-1:OFS_W] == BNUM_W'($past(pc_o[PC_W-1:OFS_W]) + 1'b1)));

  // R4: idle holds
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!br_valid_i && !adv_i) |=> ($stable(pc_o) && !bundle_chg_o));

  // R5: accepted branch loads target
  assert_branch_load_R5: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && br_target_i[OFS_W-1:0] <= tgt_last_i) |=>
      (pc_o == $past(br_target_i) && !pc_err_o));

  // R7: refused branch
  assert_branch_refuse_R7: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && br_target_i[OFS_W-1:0] > tgt_last_i) |=>
      (pc_err_o && $stable(pc_o) && !bundle_chg_o));

  // R8: error flag sticky without a branch
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (pc_err_o && !br_valid_i) |=> pc_err_o);

endmodule

// File: tb/bundle_pc_seq_test.sv
module bundle_pc_seq_test;

  localparam int unsigned OW = 3;
  localparam int unsigned PW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adv = 1'b0;
  logic [OW-1:0] cur_last = '0;
  logic          br = 1'b0;
  logic [PW-1:0] tgt = '0;
  logic [OW-1:0] tgt_last = '0;
  logic [PW-1:0] pc;
  logic          chg;
  logic          err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bundle_pc_seq uut (
    .clk(clk), .rst(rst), .adv_i(adv), .cur_last_i(cur_last),
    .br_valid_i(br), .br_target_i(tgt), .tgt_last_i(tgt_last),
    .pc_o(pc), .bundle_chg_o(chg), .pc_err_o(err)
  );

  typedef struct packed {
    logic          a;
    logic          b;
    logic [31:0]   t;
    logic [2:0]    tl;
    logic [2:0]    cl;
    logic [31:0]   pc;
    logic          chg;
    logic          err;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 32'd0,  3'd0, 3'd2, 32'd1,  1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 32'd0,  3'd0, 3'd2, 32'd2,  1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 32'd0,  3'd0, 3'd2, 32'd8,  1'b1, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b0, 32'd0,  3'd0, 3'd2, 32'd8,  1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 32'd0,  3'd0, 3'd0, 32'd16, 1'b1, 1'b0, 4'd3},  // R3 one-slot bundle
    '{1'b0, 1'b1, 32'd43, 3'd3, 3'd0, 32'd43, 1'b1, 1'b0, 4'd6},  // R6 cross
    '{1'b1, 1'b1, 32'd41, 3'd3, 3'd3, 32'd41, 1'b0, 1'b0, 4'd9},  // R9 and same bundle
    '{1'b0, 1'b1, 32'd78, 3'd5, 3'd3, 32'd41, 1'b0, 1'b1, 4'd7},  // R7
    '{1'b1, 1'b0, 32'd0,  3'd0, 3'd3, 32'd42, 1'b0, 1'b1, 4'd8},  // R8 advance keeps flag
    '{1'b0, 1'b0, 32'd0,  3'd0, 3'd3, 32'd42, 1'b0, 1'b1, 4'd8},  // R8 idle keeps flag
    '{1'b0, 1'b1, 32'd77, 3'd5, 3'd3, 32'd77, 1'b1, 1'b0, 4'd5},  // R5 clears flag
    '{1'b1, 1'b0, 32'd0,  3'd0, 3'd7, 32'd78, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 32'd0,  3'd0, 3'd4, 32'd80, 1'b1, 1'b0, 4'd3},  // R3 slot above count
    '{1'b0, 1'b1, 32'd7,  3'd7, 3'd0, 32'd7,  1'b1, 1'b0, 4'd5}   // R5 top slot
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string r, input logic [PW-1:0] epc,
                       input logic ec, input logic ee);
    n_chk++;
    if (pc !== epc || chg !== ec || err !== ee) begin
      n_bad++;
      $display("FAIL %s: pc=%0h chg=%0b err=%0b expected pc=%0h chg=%0b err=%0b",
               r, pc, chg, err, epc, ec, ee);
    end
  endtask

  // Inputs change on the falling edge; results are read one edge later
  task automatic step(input logic a, input logic b, input logic [PW-1:0] t,
                      input logic [OW-1:0] tl, input logic [OW-1:0] cl);
    adv = a; br = b; tgt = t; tgt_last = tl; cur_last = cl;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 32'd0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 32'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].a, TBL[i].b, TBL[i].t, TBL[i].tl, TBL[i].cl);
      check(rname(TBL[i].req), TBL[i].pc, TBL[i].chg, TBL[i].err);
    end

    // R3: pulse lasts one cycle only
    step(1'b1, 1'b0, 0, 0, 3'd7);          // pc 7 -> bundle 1 slot 0
    check("R3", 32'd8, 1'b1, 1'b0);
    step(1'b0, 1'b0, 0, 0, 0);
    check("R3", 32'd8, 1'b0, 1'b0);

    // R7 with advance in the same cycle: advance dropped
    step(1'b1, 1'b1, 32'd20, 3'd3, 3'd7);
    check("R7", 32'd8, 1'b0, 1'b1);
    // R8: a second refused branch keeps the flag
    step(1'b0, 1'b1, 32'd31, 3'd6, 0);
    check("R8", 32'd8, 1'b0, 1'b1);

    // R1: reset in mid run clears the flag and the PC
    rst = 1'b1;
    step(1'b0, 1'b0, 0, 0, 0);
    check("R1", 32'd0, 1'b0, 1'b0);
    rst = 1'b0;

    // R10: bundle number wraps from all ones to zero
    step(1'b0, 1'b1, 32'hFFFF_FFF8, 3'd0, 0);
    check("R10", 32'hFFFF_FFF8, 1'b1, 1'b0);
    step(1'b1, 1'b0, 0, 0, 3'd0);
    check("R10", 32'd0, 1'b1, 1'b0);

    adv = 1'b0; br = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule